// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures the rate of an on-chip ring oscillator against the reference clock. A controller places a window length, in reference cycles, on a wide count input and raises a measure-enable level. The meter opens a gate in the reference domain for exactly that many reference cycles. The oscillator domain counts its own cycles while it sees the gate open. When the gate closes, the oscillator count is handed back, a sticky valid flag is raised and the count is presented as the result. A calibration flow typically uses a 1024-cycle window and polls the valid flag.

A free-running enable input gates the measurement. While it is low, the reference window does not advance and oscillator cycles are not counted. The gate and the free-running enable are carried into the oscillator domain through two-flop synchronisers. Completion comes back as a toggle through a two-flop synchroniser. The count itself crosses as a quasi-static word that does not change until the next window opens.

If the oscillator never answers within a bounded number of reference cycles after the window closes, the meter still completes and reports a count of zero. A downstream stage can then detect the dead oscillator. Clearing the measure-enable aborts any window in progress and clears the flag and result. Raising it again starts a fresh window.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, valid_o is 0 and result_o is 0.
- R2: The gate stays open for exactly max(win_cycles_i,1) reference cycles in which free_run_en_i is high. A value of 0 is treated as 1. valid_o stays 0 while the gate is open.
- R3: result_o equals the number of oscillator cycles in the window, within ±2 cycles of quantisation. valid_o rises no later than 3 oscillator cycles plus 5 reference cycles after the window closes.
- R4: Once valid_o is set with meas_en_i held high, valid_o stays 1 and result_o stays constant. No new window opens until meas_en_i has been low.
- R5: One reference cycle after meas_en_i is sampled low, valid_o and result_o are 0. Any window in progress is abandoned.
- R6: Raising meas_en_i again opens a fresh window whose count starts from zero, provided meas_en_i was low for at least four oscillator periods.
- R7: While free_run_en_i is low, the window does not advance and valid_o is not set. Once it is raised, the measurement completes normally.
- R8: If the oscillator returns no completion, valid_o rises exactly TMO_CYC reference cycles after the window closes, with result_o equal to 0.
- R9: The oscillator count saturates at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| osc_clk_i | input | 1 | Ring oscillator clock being measured |
| meas_en_i | input | 1 | Measure enable level; low clears and disarms |
| free_run_en_i | input | 1 | Free-running measurement enable |
| win_cycles_i | input | WIN_W | Window length in reference cycles |
| valid_o | output | 1 | Sticky measurement-complete flag |
| result_o | output | CNT_W | Oscillator cycles counted in the window |

## Verification
The gate opens on the reference edge that samples meas_en_i high. It closes on the edge after win_cycles_i further enabled cycles. Counting from the edge that samples the enable, valid_o can therefore rise no earlier than the third edge after the gate closes. The bench samples valid_o low one cycle after the close. It then polls for valid_o within a bound of three oscillator periods, rounded up to reference cycles, plus five reference cycles. When the window is shorter than two oscillator periods, the oscillator may never see the gate, so the bound is the timeout instead. The timeout case and the clear are exact: valid_o must be low after win+TMO_CYC edges and high after one more, and the clear must show on the first edge that samples meas_en_i low. All samples are taken on the falling reference edge.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WIN,
    ST_WAIT,
    ST_DONE
  } meter_st_e;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fm_osc_cnt.sv
`timescale 1ns/1ps
module fm_osc_cnt #(
  parameter int CNT_W = 24
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_q;
  logic             gate_rise, gate_fall;
  logic [CNT_W-1:0] cnt_q;
  logic             tgl_q;

  assign gate_rise = gate_i & ~gate_q;
  assign gate_fall = ~gate_i & gate_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      gate_q <= gate_i;
      // new window: restart, counting this edge if enabled
      if (gate_rise)
        cnt_q <= CNT_W'(run_i);
      else if (gate_i && run_i && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
      if (gate_fall)
        tgl_q <= ~tgl_q;
    end
  end

  assign cnt_o      = cnt_q;
  assign done_tgl_o = tgl_q;
endmodule

// File: rtl/fm_ref_ctrl.sv
`timescale 1ns/1ps
module fm_ref_ctrl
  import fm_pkg::*;
#(
  parameter int WIN_W   = 24,
  parameter int CNT_W   = 24,
  parameter int TMO_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_en_i,
  input  logic             free_run_en_i,
  input  logic [WIN_W-1:0] win_cycles_i,
  input  logic             done_tgl_i,
  input  logic [CNT_W-1:0] osc_cnt_i,
  output logic             gate_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] result_o
);
  localparam int             TMO_W    = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
  localparam int             EXT_W    = WIN_W + 1;

  meter_st_e        state_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [TMO_W-1:0] tmo_q;
  logic             tgl_q;
  logic             gate_q, valid_q;
  logic [CNT_W-1:0] result_q;
  logic             win_last, handback;

  assign win_last = (EXT_W'(win_cnt_q) + EXT_W'(1)) >= EXT_W'(win_cycles_i);
  assign handback = done_tgl_i ^ tgl_q;

  // edge tracker runs always so stale toggles are consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= done_tgl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      win_cnt_q <= '0;
      tmo_q     <= '0;
      gate_q    <= 1'b0;
      valid_q   <= 1'b0;
      result_q  <= '0;
    end else if (!meas_en_i) begin
      state_q   <= ST_IDLE;
      win_cnt_q <= '0;
      tmo_q     <= '0;
      gate_q    <= 1'b0;
      valid_q   <= 1'b0;
      result_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q   <= ST_WIN;
          gate_q    <= 1'b1;
          win_cnt_q <= '0;
        end
        ST_WIN: begin
          if (free_run_en_i) begin
            if (win_last) begin
              gate_q  <= 1'b0;
              tmo_q   <= '0;
              state_q <= ST_WAIT;
            end else begin
              win_cnt_q <= win_cnt_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (handback) begin
            result_q <= osc_cnt_i;
            valid_q  <= 1'b1;
            state_q  <= ST_DONE;
          end else if (tmo_q == TMO_LAST) begin
            result_q <= '0;
            valid_q  <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign gate_o   = gate_q;
  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/osc_freq_meter.sv
`timescale 1ns/1ps
module osc_freq_meter #(
  parameter int WIN_W   = 24,
  parameter int CNT_W   = 24,
  parameter int TMO_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_clk_i,
  input  logic             meas_en_i,
  input  logic             free_run_en_i,
  input  logic [WIN_W-1:0] win_cycles_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] result_o
);
  logic             win_gate;
  logic [1:0]       osc_ctl_s;
  logic [CNT_W-1:0] osc_cnt;
  logic             osc_tgl, osc_tgl_s;

  fm_sync #(.W(2), .STAGES(2)) u_sync_to_osc (
    .clk_i  (osc_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({free_run_en_i, win_gate}),
    .q_o    (osc_ctl_s)
  );

  fm_osc_cnt #(.CNT_W(CNT_W)) u_osc_cnt (
    .osc_clk_i  (osc_clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (osc_ctl_s[0]),
    .run_i      (osc_ctl_s[1]),
    .cnt_o      (osc_cnt),
    .done_tgl_o (osc_tgl)
  );

  fm_sync #(.W(1), .STAGES(2)) u_sync_to_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (osc_tgl),
    .q_o    (osc_tgl_s)
  );

  fm_ref_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_ref_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .meas_en_i     (meas_en_i),
    .free_run_en_i (free_run_en_i),
    .win_cycles_i  (win_cycles_i),
    .done_tgl_i    (osc_tgl_s),
    .osc_cnt_i     (osc_cnt),
    .gate_o        (win_gate),
    .valid_o       (valid_o),
    .result_o      (result_o)
  );
endmodule

// File: rtl/osc_freq_meter_chk.sv
`timescale 1ns/1ps
module osc_freq_meter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             meas_en_i,
  input logic             free_run_en_i,
  input logic             gate_i,
  input logic             valid_o,
  input logic [CNT_W-1:0] result_o
);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_en_i |=> (!valid_o && (result_o == '0)));

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && meas_en_i) |=> (valid_o && $stable(result_o)));

  a_r7_hold_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && meas_en_i && !free_run_en_i) |=> gate_i);

  a_r2_no_valid_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |-> !valid_o);

  a_r6_fresh_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(meas_en_i) |=> (gate_i && !valid_o));
endmodule

bind osc_freq_meter osc_freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .meas_en_i     (meas_en_i),
  .free_run_en_i (free_run_en_i),
  .gate_i        (win_gate),
  .valid_o       (valid_o),
  .result_o      (result_o)
);

// File: tb/osc_freq_meter_tb_top.sv
`timescale 1ns/1ps
module osc_freq_meter_tb_top;
  localparam int WIN_W = 11;
  localparam int CNT_W = 8;
  localparam int TMO   = 32;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk_i = 1'b0;
  logic osc_clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic meas_en_i = 1'b0;
  logic free_run_en_i = 1'b0;
  logic [WIN_W-1:0] win_cycles_i = '0;
  logic valid_o;
  logic [CNT_W-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  realtime osc_half = 3.5;
  bit osc_run = 1'b1;

  always #5 clk_i = ~clk_i;
  initial forever begin
    #(osc_half);
    if (osc_run) osc_clk_i = ~osc_clk_i;
  end

  osc_freq_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .TMO_CYC(TMO)) dut_i (
    .clk_i, .rst_ni, .osc_clk_i, .meas_en_i, .free_run_en_i,
    .win_cycles_i, .valid_o, .result_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_en(input string req);
    meas_en_i = 1'b0;
    cyc(1);
    chk(valid_o == 1'b0, req, int'(valid_o), 0);
    chk(result_o == '0, req, int'(result_o), 0);
    cyc(10);
  endtask

  // full measurement from idle; enable applied at a falling edge
  task automatic run_meas(input int win, input real tosc, input string req);
    int weff, bound, n, held;
    real exp_r, diff;
    weff = (win == 0) ? 1 : win;
    osc_half = tosc / 2.0;
    osc_run = 1'b1;
    free_run_en_i = 1'b1;
    win_cycles_i = WIN_W'(win);
    cyc(4);
    meas_en_i = 1'b1;
    cyc(weff + 1);
    chk(valid_o == 1'b0, "R2", int'(valid_o), 0);
    bound = 5 + 3 * (int'(tosc / 10.0) + 1);
    if (weff * 10 < 2 * tosc) bound = TMO + 2;
    n = 0;
    while (!valid_o && n < bound) begin
      cyc(1);
      n++;
    end
    chk(valid_o == 1'b1, "R3", n, bound);
    exp_r = weff * 10.0 / tosc;
    if (exp_r > CMAX) exp_r = CMAX;
    diff = real'(result_o) - exp_r;
    chk(diff <= 2.0 && diff >= -2.0, (exp_r >= CMAX) ? "R9" : req,
        int'(result_o), int'(exp_r));
    held = int'(result_o);
    cyc(2 * weff + 5);
    chk(valid_o == 1'b1, "R4", int'(valid_o), 1);
    chk(int'(result_o) == held, "R4", int'(result_o), held);
    clear_en("R5");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    real periods[5];
    int wins[7];
    periods = '{4.0, 7.0, 13.0, 23.5, 50.0};
    wins = '{1, 3, 17, 100, 255, 1024, 0};
    cyc(3);
    chk(valid_o == 1'b0, "R1", int'(valid_o), 0);
    chk(result_o == '0, "R1", int'(result_o), 0);
    rst_ni = 1'b1;
    cyc(3);
    chk(valid_o == 1'b0 && result_o == '0, "R1", int'(result_o), 0);

    foreach (wins[w])
      foreach (periods[p])
        run_meas(wins[w], periods[p], "R3");

    // R9: strong saturation
    run_meas(200, 3.0, "R9");

    // R7: free-running enable held low stalls the window
    osc_half = 6.5;
    free_run_en_i = 1'b0;
    win_cycles_i = WIN_W'(20);
    cyc(4);
    meas_en_i = 1'b1;
    cyc(200);
    chk(valid_o == 1'b0, "R7", int'(valid_o), 0);
    free_run_en_i = 1'b1;
    begin
      int n = 0;
      real d;
      while (!valid_o && n < 40) begin
        cyc(1);
        n++;
      end
      chk(valid_o == 1'b1, "R7", int'(valid_o), 1);
      d = real'(result_o) - 200.0 / 13.0;
      chk(d <= 4.0 && d >= -4.0, "R7", int'(result_o), 15);
    end
    clear_en("R5");

    // R6: abort a window midway, then start afresh
    win_cycles_i = WIN_W'(200);
    meas_en_i = 1'b1;
    cyc(50);
    chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
    clear_en("R5");
    run_meas(200, 13.0, "R6");

    // R8: stopped oscillator, exact timeout and zero result
    osc_run = 1'b0;
    win_cycles_i = WIN_W'(10);
    cyc(4);
    meas_en_i = 1'b1;
    cyc(10 + TMO);
    chk(valid_o == 1'b0, "R8", int'(valid_o), 0);
    cyc(1);
    chk(valid_o == 1'b1, "R8", int'(valid_o), 1);
    chk(result_o == '0, "R8", int'(result_o), 0);
    clear_en("R5");
    osc_run = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule